// File: doc/BRIEF.md
# Flash Read Fault Status Register

This block records fault events from a flash controller's read path in two sticky flags: one for single-bit faults that ECC corrected, one for uncorrectable double-bit faults. A read result arrives as a one-cycle strobe with its ECC verdict. The command-busy indication from the memory controller is sampled on that same strobe. If a read lands on the block while a flash command is executing, the read is treated as an access collision. A collision is reported by raising both flags together. ECC faults on their own never raise both.

Software observes and clears the flags through a small register port. It has a one-cycle write strobe, a 3-bit address and 8-bit data, and the read data path is combinational. A second register holds two interrupt enables, one for each flag. Each interrupt output is driven high while its flag and its enable are both set. Single-bit reporting can be switched off with the ignore-single input. This input does not mask collisions. The read-result input has no ready signal and no back-pressure: every strobe is accepted in the cycle it is presented.

Top module: `flash_rd_fault_status`

## Requirements
- R1: After reset, both registers read 0x00 and both interrupt outputs are low.
- R2: Address 0 is the status register, with bit 1 as the double-bit flag and bit 0 as the single-bit flag. Address 1 holds the interrupt enables, with bit 1 for double-bit and bit 0 for single-bit. Bits 7..2 of both registers read 0, and addresses 2 to 7 read 0x00.
- R3: A read strobe with cmd_busy=0 and rd_ecc_double=1 sets the double-bit flag on that clock edge.
- R4: A read strobe with cmd_busy=0, rd_ecc_double=0 and rd_ecc_single=1 sets the single-bit flag only when ignore_single=0. When ignore_single=1 it has no effect.
- R5: A read strobe with cmd_busy=1 is a collision. It sets both flags, whatever the ECC inputs and ignore_single are.
- R6: A read strobe with cmd_busy=0 and both ECC inputs high is taken as a double-bit fault only, because ECC reports are mutually exclusive. The single-bit flag is not set by that strobe.
- R7: Writing 1 to a status bit clears that flag. Writing 0 leaves the flag unchanged. ECC and busy inputs have no effect unless rd_valid is high.
- R8: When a set event and a write-1-to-clear reach the same flag on the same edge, the flag ends up 1.
- R9: irq_single equals single flag AND enable bit 0. irq_double equals double flag AND enable bit 1.
- R10: No register write ever sets a flag. Writes to addresses 2 to 7 change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | One-cycle strobe: a flash array read result is present |
| rd_ecc_single | input | 1 | ECC corrected a single-bit fault on this read |
| rd_ecc_double | input | 1 | ECC found an uncorrectable double-bit fault |
| cmd_busy | input | 1 | Memory controller is executing a command on this block |
| ignore_single | input | 1 | Suppress single-bit fault reporting |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| irq_single | output | 1 | Single-bit fault interrupt |
| irq_double | output | 1 | Double-bit fault interrupt |

## Verification
The flags and the enable register change on the clock edge where the read strobe or write strobe is sampled, so every result is due one edge after its stimulus. The bench drives inputs at a falling edge and drops them at the next falling edge. It then reads back the status after the rising edge in between. reg_rdata and the interrupt outputs follow the registers combinationally, so they are checked in the same half-cycle without any added delay. The sweep covers every combination of the five read-path inputs, four starting flag states and four clear masks, applied together on one edge.

// File: rtl/fault_stat_pkg.sv
package fault_stat_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int NUM_FLAGS = 2;
  localparam int IDX_SGL   = 0;
  localparam int IDX_DBL   = 1;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_IRQEN  = 3'd1;

  typedef enum logic [1:0] {
    EV_NONE,
    EV_SINGLE,
    EV_DOUBLE,
    EV_COLLIDE
  } read_event_e;
endpackage

// File: rtl/fault_classify.sv
module fault_classify
  import fault_stat_pkg::*;
(
  input  logic                 rd_valid,
  input  logic                 rd_ecc_single,
  input  logic                 rd_ecc_double,
  input  logic                 cmd_busy,
  input  logic                 ignore_single,
  output logic [NUM_FLAGS-1:0] set_vec
);
  read_event_e ev;

  // Collision outranks ECC; double outranks single (exclusive reports).
  always_comb begin
    ev = EV_NONE;
    if (rd_valid) begin
      if (cmd_busy)                             ev = EV_COLLIDE;
      else if (rd_ecc_double)                   ev = EV_DOUBLE;
      else if (rd_ecc_single && !ignore_single) ev = EV_SINGLE;
    end
  end

  always_comb begin
    set_vec = '0;
    unique case (ev)
      EV_SINGLE:  set_vec[IDX_SGL] = 1'b1;
      EV_DOUBLE:  set_vec[IDX_DBL] = 1'b1;
      EV_COLLIDE: set_vec          = '1;
      default:    set_vec          = '0;
    endcase
  end
endmodule

// File: rtl/fault_flag_cell.sv
module fault_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // Hardware set wins over a same-edge software clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/fault_regfile.sv
module fault_regfile
  import fault_stat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic [NUM_FLAGS-1:0] clr_vec,
  output logic [NUM_FLAGS-1:0] irq_en,
  output logic [DATA_W-1:0]    reg_rdata
);
  logic wr_status, wr_irqen;
  logic unused_wbits;

  assign wr_status    = reg_wr && (reg_addr == ADDR_STATUS);
  assign wr_irqen     = reg_wr && (reg_addr == ADDR_IRQEN);
  assign clr_vec      = wr_status ? reg_wdata[NUM_FLAGS-1:0] : '0;
  assign unused_wbits = ^reg_wdata[DATA_W-1:NUM_FLAGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq_en <= '0;
    else if (wr_irqen) irq_en <= reg_wdata[NUM_FLAGS-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_STATUS: reg_rdata[NUM_FLAGS-1:0] = flags;
      ADDR_IRQEN:  reg_rdata[NUM_FLAGS-1:0] = irq_en;
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/flash_rd_fault_status.sv
module flash_rd_fault_status
  import fault_stat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_valid,
  input  logic        rd_ecc_single,
  input  logic        rd_ecc_double,
  input  logic        cmd_busy,
  input  logic        ignore_single,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        irq_single,
  output logic        irq_double
);
  logic [NUM_FLAGS-1:0] set_vec, clr_vec, flag_q, irq_en, irq_vec;

  fault_classify u_classify (
    .rd_valid      (rd_valid),
    .rd_ecc_single (rd_ecc_single),
    .rd_ecc_double (rd_ecc_double),
    .cmd_busy      (cmd_busy),
    .ignore_single (ignore_single),
    .set_vec       (set_vec)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    fault_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec[g]),
      .clr_i  (clr_vec[g]),
      .flag_o (flag_q[g])
    );
  end

  fault_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .flags     (flag_q),
    .clr_vec   (clr_vec),
    .irq_en    (irq_en),
    .reg_rdata (reg_rdata)
  );

  assign irq_vec    = flag_q & irq_en;
  assign irq_single = irq_vec[IDX_SGL];
  assign irq_double = irq_vec[IDX_DBL];
endmodule

// File: rtl/fault_stat_checker.sv
module fault_stat_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_valid,
  input logic       rd_ecc_single,
  input logic       rd_ecc_double,
  input logic       cmd_busy,
  input logic       ignore_single,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       irq_single,
  input logic       irq_double,
  input logic [1:0] flag_q
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (flag_q == 2'b00));

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd0) |-> (reg_rdata[7:2] == 6'd0));

  p_double_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !cmd_busy && rd_ecc_double) |=> flag_q[1]);

  p_ignore_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !cmd_busy && ignore_single && !rd_ecc_double && !flag_q[0])
      |=> !flag_q[0]);

  p_collision_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && cmd_busy) |=> (flag_q == 2'b11));

  p_sticky_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[0] && !(reg_wr && reg_addr == 3'd0 && reg_wdata[0])) |=> flag_q[0]);

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_single |-> flag_q[0]) and (irq_double |-> flag_q[1]));

  p_no_write_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && flag_q == 2'b00) |=> (flag_q == 2'b00));
endmodule

bind flash_rd_fault_status fault_stat_checker i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rd_valid      (rd_valid),
  .rd_ecc_single (rd_ecc_single),
  .rd_ecc_double (rd_ecc_double),
  .cmd_busy      (cmd_busy),
  .ignore_single (ignore_single),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .reg_rdata     (reg_rdata),
  .irq_single    (irq_single),
  .irq_double    (irq_double),
  .flag_q        (flag_q)
);

// File: tb/test_flash_rd_fault_status.sv
module test_flash_rd_fault_status;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rd_valid, rd_ecc_single, rd_ecc_double, cmd_busy, ignore_single;
  logic       reg_wr;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq_single, irq_double;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_rd_fault_status i_flash_rd_fault_status (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid),
    .rd_ecc_single(rd_ecc_single), .rd_ecc_double(rd_ecc_double),
    .cmd_busy(cmd_busy), .ignore_single(ignore_single),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_single(irq_single), .irq_double(irq_double)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    rd_valid = 0; rd_ecc_single = 0; rd_ecc_double = 0; cmd_busy = 0;
    ignore_single = 0; reg_wr = 0; reg_wdata = 8'h00; reg_addr = 3'd0;
  endtask

  // One edge of stimulus; results sampled at the following falling edge.
  task automatic step(input logic v, input logic s, input logic d, input logic b,
                      input logic ign, input logic wr, input logic [2:0] a,
                      input logic [7:0] wd);
    @(negedge clk);
    rd_valid = v; rd_ecc_single = s; rd_ecc_double = d; cmd_busy = b;
    ignore_single = ign; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    @(negedge clk);
    idle_inputs();
    #1;
  endtask

  task automatic preset(input logic [1:0] st);
    step(0, 0, 0, 0, 0, 1, 3'd0, 8'hFF);
    if (st == 2'b11)      step(1, 0, 0, 1, 0, 0, 3'd0, 8'h00);
    else if (st == 2'b10) step(1, 0, 1, 0, 0, 0, 3'd0, 8'h00);
    else if (st == 2'b01) step(1, 1, 0, 0, 0, 0, 3'd0, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    reg_addr = 3'd0; #1; check("R1 status", reg_rdata, 8'h00);
    reg_addr = 3'd1; #1; check("R1 irqen", reg_rdata, 8'h00);
    check("R1 irqs", {6'd0, irq_double, irq_single}, 8'h00);

    // R10 writes never set flags
    step(0, 0, 0, 0, 0, 1, 3'd0, 8'hFF);
    check("R10 write-all-ones", reg_rdata, 8'h00);

    // R2 enable register layout and unused addresses
    step(0, 0, 0, 0, 0, 1, 3'd1, 8'hFF);
    reg_addr = 3'd1; #1; check("R2 irqen width", reg_rdata, 8'h03);
    preset(2'b11);
    for (int a = 2; a < 8; a++) begin
      step(0, 0, 0, 0, 0, 1, a[2:0], 8'hFF);
      reg_addr = a[2:0]; #1; check("R2 unused addr read", reg_rdata, 8'h00);
      reg_addr = 3'd0; #1; check("R10 unused write status", reg_rdata, 8'h03);
      reg_addr = 3'd1; #1; check("R10 unused write irqen", reg_rdata, 8'h03);
    end

    // R9 interrupt gating sweep
    for (int st = 1; st < 4; st++) begin
      for (int en = 0; en < 4; en++) begin
        preset(st[1:0]);
        step(0, 0, 0, 0, 0, 1, 3'd1, en[7:0]);
        check("R9 irq", {6'd0, irq_double, irq_single}, 8'(st & en));
      end
    end
    step(0, 0, 0, 0, 0, 1, 3'd1, 8'h00);

    // Exhaustive sweep: read-path inputs x start state x clear mask
    for (int st = 0; st < 4; st++) begin
      for (int m = 0; m < 4; m++) begin
        for (int c = 0; c < 32; c++) begin
          logic v, s, d, b, ign;
          logic [1:0] setv, expv;
          string tag;
          v = c[0]; s = c[1]; d = c[2]; b = c[3]; ign = c[4];
          if (!v)      setv = 2'b00;
          else if (b)  setv = 2'b11;
          else if (d)  setv = 2'b10;
          else if (s && !ign) setv = 2'b01;
          else         setv = 2'b00;
          expv = (st[1:0] & ~m[1:0]) | setv;
          if ((setv & m[1:0] & st[1:0]) != 0) tag = "R8 set-over-clear";
          else if (v && b)   tag = "R5 collision";
          else if (v && d && s) tag = "R6 exclusive";
          else if (v && d)   tag = "R3 double";
          else if (v && s)   tag = "R4 single/ignore";
          else               tag = "R7 clear/no-valid";
          preset(st[1:0]);
          step(v, s, d, b, ign, (m != 0), 3'd0, {6'b111111, m[1:0]});
          reg_addr = 3'd0; #1;
          check(tag, reg_rdata, {6'd0, expv});
        end
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule